// File: doc/BRIEF.md
# Transmit Status Sticky Register

This block holds the transmit-side status word of an Ethernet MAC. Single-cycle event strobes from the transmitter and its DMA engine set sticky flags. Each flag stays set until software clears it by writing a 1 to its bit position. A software write can never set a flag.

Each strobe is qualified by the current operating mode before it reaches a flag. The gigabit/10-100 speed select decides where a late collision is recorded. The packet-buffer select blocks every underrun source and enables the oversized-frame error. The FIFO underflow input counts only while a frame is in flight.

Bit 3 carries the live transmit-active level and has no storage. An interrupt line is the OR of all stored flags. Reads are combinational and have no side effects.

Top module: `tx_status_reg`

## Requirements
- R1: After reset every stored flag is 0. Bits 31:9 always read 0, and writes to them have no effect.
- R2: A write clears each stored flag whose `reg_wdata` bit is 1. A write never sets a flag: writing 1 to a clear flag leaves it at 0.
- R3: Bit 3 of `reg_rdata` always equals `tx_active`. It is not stored.
- R4: Bit 1 (collision) is set one cycle after `ev_coll`. When `gig_mode` is 0, it is also set one cycle after `ev_late_coll`.
- R5: Bit 7 (late collision) is set by `ev_late_coll` only when `gig_mode` is 1. In that mode a late collision leaves bit 1 unchanged.
- R6: Bit 6 (underrun) is set one cycle after any of these:
  - `ev_data_starve`;
  - `ev_wb_overlap`;
  - `ev_fifo_underflow` while `tx_active` is 1.

  `ev_fifo_underflow` while `tx_active` is 0 has no effect.
- R7: When `pkt_buf_mode` is 1, bit 6 is never set, whatever strobes occur.
- R8: Bit 4 (bus error) is set one cycle after `ev_bus_err` or `ev_buf_exhaust`. `ev_frame_oversize` sets it only when `pkt_buf_mode` is 1.
- R9: When a set strobe and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R10: `irq` equals the OR of bits 8:4 and 2:0 of `reg_rdata`, in the same cycle.
- R11: Bits 0, 2, 5 and 8 are set one cycle after `ev_used_rd`, `ev_retry_lim`, `ev_frame_done` and `ev_resp_bad` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data; a 1 clears the matching flag |
| reg_rdata | output | 32 | Register read value |
| irq | output | 1 | OR of all stored flags |
| gig_mode | input | 1 | 1 = gigabit, 0 = 10/100 |
| pkt_buf_mode | input | 1 | 1 = DMA packet-buffer mode |
| tx_active | input | 1 | Live transmit-active level |
| ev_used_rd | input | 1 | Descriptor read with used bit set |
| ev_coll | input | 1 | Collision |
| ev_late_coll | input | 1 | Late collision |
| ev_retry_lim | input | 1 | Retry limit exceeded |
| ev_data_starve | input | 1 | Frame aborted, data ran out |
| ev_wb_overlap | input | 1 | Status write-back while one is pending |
| ev_fifo_underflow | input | 1 | External FIFO underflow |
| ev_frame_done | input | 1 | Frame transmitted |
| ev_bus_err | input | 1 | Bus error mid frame |
| ev_buf_exhaust | input | 1 | Buffers exhausted mid frame |
| ev_frame_oversize | input | 1 | Frame larger than packet buffer |
| ev_resp_bad | input | 1 | Bad bus response |

## Verification
The assertions assume that all inputs are known (no X or Z) once reset is released. They also assume that `reset` is synchronous.

Strobes may arrive in any cycle and in any combination. Mode selects may change in any cycle, and a flag's origin is always judged against the mode seen on the cycle before it rose.

The stimulus follows these assumptions:
- It drives every input from the bench at the falling edge.
- It draws each strobe with low probability.
- It toggles the mode selects freely.
- It mixes full-width write data, including reserved bits, with the strobes.

// File: rtl/tx_status_pkg.sv
package tx_status_pkg;
   // flag positions are decoded by software, so they are fixed
   localparam int unsigned FLAG_N     = 9;
   localparam int unsigned B_USED     = 0;
   localparam int unsigned B_COLL     = 1;
   localparam int unsigned B_RETRY    = 2;
   localparam int unsigned B_ACTIVE   = 3;
   localparam int unsigned B_BUSERR   = 4;
   localparam int unsigned B_DONE     = 5;
   localparam int unsigned B_UNDER    = 6;
   localparam int unsigned B_LATE     = 7;
   localparam int unsigned B_RESP     = 8;
   localparam logic [FLAG_N-1:0] STICKY_MASK = 9'h1F7;
endpackage

// File: rtl/tx_stat_qualify.sv
module tx_stat_qualify
   import tx_status_pkg::*;
(
   input  logic              gig_mode,
   input  logic              pkt_buf_mode,
   input  logic              tx_active,
   input  logic              ev_used_rd,
   input  logic              ev_coll,
   input  logic              ev_late_coll,
   input  logic              ev_retry_lim,
   input  logic              ev_data_starve,
   input  logic              ev_wb_overlap,
   input  logic              ev_fifo_underflow,
   input  logic              ev_frame_done,
   input  logic              ev_bus_err,
   input  logic              ev_buf_exhaust,
   input  logic              ev_frame_oversize,
   input  logic              ev_resp_bad,
   output logic [FLAG_N-1:0] set_vec
);
   logic under_any;

   assign under_any = ev_data_starve | ev_wb_overlap | (ev_fifo_underflow & tx_active);

   always_comb begin
      set_vec           = '0;
      set_vec[B_USED]   = ev_used_rd;
      set_vec[B_COLL]   = ev_coll | (ev_late_coll & ~gig_mode);
      set_vec[B_RETRY]  = ev_retry_lim;
      set_vec[B_BUSERR] = ev_bus_err | ev_buf_exhaust | (ev_frame_oversize & pkt_buf_mode);
      set_vec[B_DONE]   = ev_frame_done;
      set_vec[B_UNDER]  = under_any & ~pkt_buf_mode;
      set_vec[B_LATE]   = ev_late_coll & gig_mode;
      set_vec[B_RESP]   = ev_resp_bad;
   end
endmodule

// File: rtl/tx_stat_cell.sv
module tx_stat_cell #(
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      q_o <= RESET_VAL;
      else if (set_i)  q_o <= 1'b1;   // set has priority over clear
      else if (clr_i)  q_o <= 1'b0;
   end
endmodule

// File: rtl/tx_status_reg.sv
module tx_status_reg
   import tx_status_pkg::*;
#(
   parameter int unsigned REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq,
   input  logic             gig_mode,
   input  logic             pkt_buf_mode,
   input  logic             tx_active,
   input  logic             ev_used_rd,
   input  logic             ev_coll,
   input  logic             ev_late_coll,
   input  logic             ev_retry_lim,
   input  logic             ev_data_starve,
   input  logic             ev_wb_overlap,
   input  logic             ev_fifo_underflow,
   input  logic             ev_frame_done,
   input  logic             ev_bus_err,
   input  logic             ev_buf_exhaust,
   input  logic             ev_frame_oversize,
   input  logic             ev_resp_bad
);
   localparam int unsigned RSVD_W = REG_W - FLAG_N;

   generate
      if (REG_W < FLAG_N + 1) begin : g_bad_width
         $error("tx_status_reg: REG_W too small for flag layout");
      end
   endgenerate

   logic [FLAG_N-1:0] set_vec;
   logic [FLAG_N-1:0] clr_vec;
   logic [FLAG_N-1:0] flags;
   logic              unused_wbits;

   assign clr_vec      = reg_wr ? reg_wdata[FLAG_N-1:0] : '0;
   assign unused_wbits = ^{reg_wdata[REG_W-1:FLAG_N], clr_vec[B_ACTIVE], set_vec[B_ACTIVE]};

   tx_stat_qualify u_qual (
      .gig_mode          (gig_mode),
      .pkt_buf_mode      (pkt_buf_mode),
      .tx_active         (tx_active),
      .ev_used_rd        (ev_used_rd),
      .ev_coll           (ev_coll),
      .ev_late_coll      (ev_late_coll),
      .ev_retry_lim      (ev_retry_lim),
      .ev_data_starve    (ev_data_starve),
      .ev_wb_overlap     (ev_wb_overlap),
      .ev_fifo_underflow (ev_fifo_underflow),
      .ev_frame_done     (ev_frame_done),
      .ev_bus_err        (ev_bus_err),
      .ev_buf_exhaust    (ev_buf_exhaust),
      .ev_frame_oversize (ev_frame_oversize),
      .ev_resp_bad       (ev_resp_bad),
      .set_vec           (set_vec)
   );

   generate
      for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
         if (STICKY_MASK[i]) begin : g_sticky
            tx_stat_cell #(.RESET_VAL(1'b0)) u_cell (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (set_vec[i]),
               .clr_i (clr_vec[i]),
               .q_o   (flags[i])
            );
            assign reg_rdata[i] = flags[i];
         end else begin : g_live
            assign flags[i]     = 1'b0;
            assign reg_rdata[i] = tx_active;
         end
      end
   endgenerate

   assign reg_rdata[REG_W-1:FLAG_N] = {RSVD_W{1'b0}};
   assign irq = |(flags & STICKY_MASK);
endmodule

// File: rtl/tx_status_chk.sv
module tx_status_chk #(
   parameter int unsigned REG_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             wbit0,
   input logic [REG_W-1:0] reg_rdata,
   input logic             irq,
   input logic             gig_mode,
   input logic             pkt_buf_mode,
   input logic             tx_active,
   input logic             ev_used_rd,
   input logic             ev_frame_done,
   input logic             ev_resp_bad
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[REG_W-1:9] == '0);                                          // R1
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && wbit0 && !ev_used_rd && reg_rdata[0]) |=> !reg_rdata[0]);  // R2
   AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[5]) |-> $past(ev_frame_done));                         // R2
   AST_LIVE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[3] == tx_active);                                            // R3
   AST_LATE_GIG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[7]) |-> $past(gig_mode));                              // R5
   AST_PKTBUF_NO_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[6]) |-> !$past(pkt_buf_mode));                         // R7
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_resp_bad |=> reg_rdata[8]);                                         // R9
   AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (|{reg_rdata[8:4], reg_rdata[2:0]}));                           // R10
endmodule

bind tx_status_reg tx_status_chk #(.REG_W(REG_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_wr        (reg_wr),
   .wbit0         (reg_wdata[0]),
   .reg_rdata     (reg_rdata),
   .irq           (irq),
   .gig_mode      (gig_mode),
   .pkt_buf_mode  (pkt_buf_mode),
   .tx_active     (tx_active),
   .ev_used_rd    (ev_used_rd),
   .ev_frame_done (ev_frame_done),
   .ev_resp_bad   (ev_resp_bad)
);

// File: tb/tx_status_reg_tb_top.sv
`timescale 1ns/1ps
module tx_status_reg_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        gig = 1'b0, pkt = 1'b0, act = 1'b0;
   logic [11:0] ev = '0;   // bench event vector, see nxt()
   logic [8:0]  exp_f = '0;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   tx_status_reg dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .gig_mode(gig), .pkt_buf_mode(pkt),
      .tx_active(act), .ev_used_rd(ev[0]), .ev_coll(ev[1]), .ev_late_coll(ev[2]),
      .ev_retry_lim(ev[3]), .ev_data_starve(ev[4]), .ev_wb_overlap(ev[5]),
      .ev_fifo_underflow(ev[6]), .ev_frame_done(ev[7]), .ev_bus_err(ev[8]),
      .ev_buf_exhaust(ev[9]), .ev_frame_oversize(ev[10]), .ev_resp_bad(ev[11])
   );

   function automatic logic [8:0] nxt(logic [8:0] old, logic [11:0] e, logic g,
                                      logic p, logic a, logic w, logic [31:0] wd);
      logic [8:0] s, c, r;
      s    = '0;
      s[0] = e[0];
      s[1] = e[1] | (e[2] & !g);
      s[2] = e[3];
      s[4] = e[8] | e[9] | (e[10] & p);
      s[5] = e[7];
      s[6] = !p & (e[4] | e[5] | (e[6] & a));
      s[7] = e[2] & g;
      s[8] = e[11];
      c    = w ? wd[8:0] : '0;
      r    = s | (old & ~c);
      r[3] = 1'b0;
      return r;
   endfunction

   function automatic logic [31:0] exp_rd(logic [8:0] f, logic a);
      logic [31:0] r;
      r    = {23'd0, f};
      r[3] = a;
      return r;
   endfunction

   task automatic chk(string req);
      logic [31:0] er;
      logic        ei;
      er = exp_rd(exp_f, act);
      ei = |(exp_f & 9'h1F7);
      checks++;
      if (reg_rdata !== er) begin
         errors++;
         $display("FAIL %s rdata actual %h expected %h", req, reg_rdata, er);
      end
      checks++;
      if (irq !== ei) begin
         errors++;
         $display("FAIL R10 irq actual %b expected %b", irq, ei);
      end
   endtask

   // drive at negedge, model at posedge, sample at next negedge
   task automatic cyc(logic [11:0] e, logic g, logic p, logic a, logic w,
                      logic [31:0] wd, string req);
      ev = e; gig = g; pkt = p; act = a; reg_wr = w; reg_wdata = wd;
      @(posedge clk);
      exp_f = nxt(exp_f, e, g, p, a, w, wd);
      @(negedge clk);
      ev = '0; reg_wr = 1'b0;
      chk(req);
   endtask

   task automatic clear_all();
      cyc(12'h0, gig, pkt, act, 1'b1, 32'hFFFF_FFFF, "R2 clear");
   endtask

   initial begin
      void'($urandom(32'd20517));
      repeat (3) @(negedge clk);
      chk("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset");

      cyc(12'h001, 0, 0, 0, 0, 0, "R11 used bit");
      cyc(12'h008, 0, 0, 0, 0, 0, "R11 retry");
      cyc(12'h080, 0, 0, 0, 0, 0, "R11 done");
      cyc(12'h800, 0, 0, 0, 0, 0, "R11 resp");
      cyc(12'h0, 0, 0, 0, 1, 32'h0000_0021, "R2 partial clear");
      cyc(12'h0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R1 R2 full clear");
      cyc(12'h0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R2 write no set");
      cyc(12'h002, 0, 0, 0, 0, 0, "R4 collision");
      clear_all();
      cyc(12'h004, 0, 0, 0, 0, 0, "R4 late in 10/100");
      clear_all();
      cyc(12'h004, 1, 0, 0, 0, 0, "R5 late in gig");
      clear_all();
      cyc(12'h070, 0, 1, 1, 0, 0, "R7 underrun blocked");
      cyc(12'h040, 0, 0, 0, 0, 0, "R6 underflow idle");
      cyc(12'h040, 0, 0, 1, 0, 0, "R6 underflow active");
      clear_all();
      cyc(12'h010, 0, 0, 0, 0, 0, "R6 starve");
      clear_all();
      cyc(12'h020, 0, 0, 0, 0, 0, "R6 wb overlap");
      clear_all();
      cyc(12'h400, 0, 0, 0, 0, 0, "R8 oversize no pkt");
      cyc(12'h400, 0, 1, 0, 0, 0, "R8 oversize pkt");
      clear_all();
      cyc(12'h100, 0, 0, 0, 0, 0, "R8 bus err");
      clear_all();
      cyc(12'h200, 0, 0, 0, 0, 0, "R8 exhaust");
      cyc(12'h800, 0, 0, 0, 1, 32'hFFFF_FFFF, "R9 set wins");
      cyc(12'h0, 0, 0, 1, 0, 0, "R3 active live");
      act = 1'b0;
      #0.5;
      chk("R3 active drop");

      for (int n = 0; n < 3000; n++) begin
         logic [11:0] e;
         for (int k = 0; k < 12; k++) e[k] = ($urandom % 8) == 0;
         cyc(e, $urandom % 2, $urandom % 2, $urandom % 2, ($urandom % 4) == 0,
             $urandom, "R4 R5 R6 R7 R8 R9 random");
      end
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL R1 watchdog actual hang expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule